// File: doc/BRIEF.md
# Fuzzy Rule Weight Evaluator

This block turns antecedent activation levels into rule weights for a fuzzy controller. A bank of activation levels (one small unsigned value per fuzzy set of the inputs) is presented in parallel. A stream of rule opcodes arrives alongside it. Each accepted opcode names up to four activation levels and says which of them are taken in complemented form. It also gives the connectives that join them. AND is evaluated as a minimum and OR as a maximum. The rule's weight is produced one clock later, with a one-cycle valid pulse and the consequent index the rule feeds.

Rules that feed the same consequent are combined by OR, so the block keeps one running maximum per consequent. With every rule weight it also reports the merged weight of that consequent, including the current rule. A marker on the first rule of an evaluation pass starts all running maxima afresh. The downstream defuzzifier reads the merged weight of the last rule of each consequent in a pass.

Top module: `fuzzy_rule_infer`

## Requirements
- R1: The opcode fields are laid out as follows. Selector k of terms 0..3 is at bits [4k+3:4k]. Complement flag k is at bit 16+k. Connective j of 0..2 is at bit 20+j. The consequent index is at bits [26:23]. `cons_idx` returns that index with the result.
- R2: A term whose complement flag is 1 uses 15 minus the selected activation level. A term whose flag is 0 uses the level as it is. Activation levels and weights are 4-bit unsigned, and level i sits at `alpha_bank[4i+3:4i]`.
- R3: Connective value 0 means AND (minimum) and value 1 means OR (maximum). The weight is ((t0 c0 t1) c1 t2) c2 t3, evaluated left to right.
- R4: A rule with fewer than four antecedents repeats a selector and flag. The result then equals the rule built from the distinct terms alone.
- R5: An opcode is accepted on a rising clock edge with `op_valid` high. The weight, merged weight and index appear after that edge, with `theta_valid` high for exactly one cycle.
- R6: While `op_valid` is low, changes on `opcode` and `op_first` have no effect. `theta_valid` stays low, all outputs hold their last values, and no running maximum changes.
- R7: `omega` is the maximum of the weights of all rules accepted for the same consequent since the last pass start, including the current rule.
- R8: An accepted rule with `op_first` high clears the running maxima of every consequent before its own weight is merged, so its `omega` equals its `theta`.
- R9: After reset all outputs are zero and every running maximum is zero.
- R10: Exactly one weight is produced per accepted rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alpha_bank | input | 64 | Sixteen 4-bit activation levels, level i in bits [4i+3:4i] |
| op_valid | input | 1 | Opcode is presented and accepted on this edge |
| op_first | input | 1 | Opcode is the first rule of an evaluation pass |
| opcode | input | 27 | Rule opcode (selectors, complement flags, connectives, consequent) |
| theta_valid | output | 1 | One-cycle pulse: result of an accepted rule is present |
| theta | output | 4 | Weight of the rule |
| omega | output | 4 | Merged weight of the rule's consequent so far |
| cons_idx | output | 4 | Consequent index of the rule |

## Verification
The evaluator is swept over all 16 complement-flag patterns and all 8 connective codes. Each combination is tried with four different permutation banks of activation levels and rotating selectors. This separates a min/max swap, a wrong evaluation order, a misplaced field and an off-by-one complement. Rules with repeated selectors show that padding a short rule changes nothing. A long stream of rules cycles over five consequents with two pass starts in it, so a running maximum that is not cleared, clears only one entry, or takes the wrong slot gives a wrong merged weight. Idle cycles with a changing opcode show that nothing moves without a valid opcode.

// File: rtl/fuzzy_inf_pkg.sv
package fuzzy_inf_pkg;

    // Connective encoding carried in the rule opcode.
    typedef enum logic {
        CONN_AND = 1'b0,
        CONN_OR  = 1'b1
    } conn_e;

endpackage

// File: rtl/fi_term_fetch.sv
// Picks each antecedent term out of the activation bank and
// optionally complements it against full scale.
module fi_term_fetch #(
    parameter int N_ALPHA = 16,
    parameter int ALPHA_W = 4,
    parameter int N_TERMS = 4,
    parameter int SEL_W   = $clog2(N_ALPHA)
) (
    input  logic [N_ALPHA*ALPHA_W-1:0] alpha_bank,
    input  logic [N_TERMS*SEL_W-1:0]   sel,
    input  logic [N_TERMS-1:0]         neg,
    output logic [N_TERMS*ALPHA_W-1:0] terms
);

    localparam logic [ALPHA_W-1:0] FULL_SCALE = '1;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [SEL_W-1:0]   sel_t;
        logic [ALPHA_W-1:0] raw_t;

        always_comb begin
            sel_t = sel[t*SEL_W +: SEL_W];
            raw_t = alpha_bank[int'(sel_t)*ALPHA_W +: ALPHA_W];
            terms[t*ALPHA_W +: ALPHA_W] = neg[t] ? (FULL_SCALE - raw_t) : raw_t;
        end
    end

endmodule

// File: rtl/fi_combine.sv
// Left-to-right min/max chain over the fetched terms.
module fi_combine
    import fuzzy_inf_pkg::*;
#(
    parameter int ALPHA_W = 4,
    parameter int N_TERMS = 4
) (
    input  logic [N_TERMS*ALPHA_W-1:0] terms,
    input  logic [N_TERMS-2:0]         conn,
    output logic [ALPHA_W-1:0]         result
);

    logic [ALPHA_W-1:0] acc;
    logic [ALPHA_W-1:0] nxt;

    always_comb begin
        acc = terms[0 +: ALPHA_W];
        for (int t = 1; t < N_TERMS; t++) begin
            nxt = terms[t*ALPHA_W +: ALPHA_W];
            if (conn_e'(conn[t-1]) == CONN_OR) begin
                acc = (nxt > acc) ? nxt : acc;
            end else begin
                acc = (nxt < acc) ? nxt : acc;
            end
        end
        result = acc;
    end

endmodule

// File: rtl/fi_merge.sv
// One running maximum per consequent; a pass start clears them all.
module fi_merge #(
    parameter int ALPHA_W = 4,
    parameter int N_CONS  = 16,
    parameter int CONS_W  = $clog2(N_CONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               first,
    input  logic [CONS_W-1:0]  cons,
    input  logic [ALPHA_W-1:0] theta,
    output logic [ALPHA_W-1:0] omega
);

    typedef logic [N_CONS-1:0][ALPHA_W-1:0] bank_t;

    bank_t              acc_d, acc_q;
    logic [ALPHA_W-1:0] base;

    always_comb begin
        base  = first ? '0 : acc_q[cons];
        omega = (theta > base) ? theta : base;
        acc_d = acc_q;
        if (accept) begin
            if (first) begin
                acc_d = '0;
            end
            acc_d[cons] = omega;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R7: the stored maximum never drops below a weight just merged.
    a_r7_acc_keeps_max: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> acc_q[$past(cons)] >= $past(theta));

    // R6: no accepted rule, no change to any running maximum.
    a_r6_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(acc_q));

endmodule

// File: rtl/fuzzy_rule_infer.sv
module fuzzy_rule_infer #(
    parameter int N_ALPHA = 16,
    parameter int ALPHA_W = 4,
    parameter int N_TERMS = 4,
    parameter int N_CONS  = 16,
    localparam int SEL_W  = $clog2(N_ALPHA),
    localparam int CONS_W = $clog2(N_CONS),
    localparam int NEG_LO  = N_TERMS*SEL_W,
    localparam int CONN_LO = NEG_LO + N_TERMS,
    localparam int CONS_LO = CONN_LO + N_TERMS - 1,
    localparam int OP_W    = CONS_LO + CONS_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_ALPHA*ALPHA_W-1:0] alpha_bank,
    input  logic                       op_valid,
    input  logic                       op_first,
    input  logic [OP_W-1:0]            opcode,
    output logic                       theta_valid,
    output logic [ALPHA_W-1:0]         theta,
    output logic [ALPHA_W-1:0]         omega,
    output logic [CONS_W-1:0]          cons_idx
);

    typedef struct packed {
        logic               valid;
        logic [ALPHA_W-1:0] theta;
        logic [ALPHA_W-1:0] omega;
        logic [CONS_W-1:0]  cons;
    } res_t;

    res_t res_d, res_q;

    logic [N_TERMS*SEL_W-1:0]   op_sel;
    logic [N_TERMS-1:0]         op_neg;
    logic [N_TERMS-2:0]         op_conn;
    logic [CONS_W-1:0]          op_cons;
    logic [N_TERMS*ALPHA_W-1:0] terms;
    logic [ALPHA_W-1:0]         rule_w;
    logic [ALPHA_W-1:0]         merged_w;

    always_comb begin
        op_sel  = opcode[0 +: N_TERMS*SEL_W];
        op_neg  = opcode[NEG_LO +: N_TERMS];
        op_conn = opcode[CONN_LO +: N_TERMS-1];
        op_cons = opcode[CONS_LO +: CONS_W];
    end

    fi_term_fetch #(
        .N_ALPHA (N_ALPHA),
        .ALPHA_W (ALPHA_W),
        .N_TERMS (N_TERMS),
        .SEL_W   (SEL_W)
    ) u_fetch (
        .alpha_bank (alpha_bank),
        .sel        (op_sel),
        .neg        (op_neg),
        .terms      (terms)
    );

    fi_combine #(
        .ALPHA_W (ALPHA_W),
        .N_TERMS (N_TERMS)
    ) u_combine (
        .terms  (terms),
        .conn   (op_conn),
        .result (rule_w)
    );

    fi_merge #(
        .ALPHA_W (ALPHA_W),
        .N_CONS  (N_CONS),
        .CONS_W  (CONS_W)
    ) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (op_valid),
        .first  (op_first),
        .cons   (op_cons),
        .theta  (rule_w),
        .omega  (merged_w)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = op_valid;
        if (op_valid) begin
            res_d.theta = rule_w;
            res_d.omega = merged_w;
            res_d.cons  = op_cons;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        theta_valid = res_q.valid;
        theta       = res_q.theta;
        omega       = res_q.omega;
        cons_idx    = res_q.cons;
    end

    // R5: each accepted opcode yields a result pulse on the next cycle.
    a_r5_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> theta_valid);

    // R6: without an accepted opcode there is no pulse and outputs hold.
    a_r6_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !theta_valid);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(theta) && $stable(omega) && $stable(cons_idx)));

    // R1: the reported index is the consequent field of the accepted opcode.
    a_r1_cons_field: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> cons_idx == $past(opcode[CONS_LO +: CONS_W]));

    // R7: a merged weight is never below the rule's own weight.
    a_r7_omega_ge_theta: assert property (@(posedge clk) disable iff (!rst_n)
        theta_valid |-> omega >= theta);

    // R8: a pass start leaves only the current rule in the maximum.
    a_r8_first_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_first) |=> omega == theta);

endmodule

// File: tb/fuzzy_rule_infer_bench.sv
module fuzzy_rule_infer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] alpha_bank;
    logic        op_valid;
    logic        op_first;
    logic [26:0] opcode;
    logic        theta_valid;
    logic [3:0]  theta;
    logic [3:0]  omega;
    logic [3:0]  cons_idx;

    int checks = 0;
    int errors = 0;
    int sent   = 0;
    int pulses = 0;
    bit done   = 1'b0;

    logic [3:0] bank_arr [16];
    logic [3:0] macc     [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    fuzzy_rule_infer u_fuzzy_rule_infer (
        .clk         (clk),
        .rst_n       (rst_n),
        .alpha_bank  (alpha_bank),
        .op_valid    (op_valid),
        .op_first    (op_first),
        .opcode      (opcode),
        .theta_valid (theta_valid),
        .theta       (theta),
        .omega       (omega),
        .cons_idx    (cons_idx)
    );

    always @(negedge clk) if (rst_n && theta_valid) pulses++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_bank(input int mul, input int add);
        for (int i = 0; i < 16; i++) begin
            bank_arr[i] = 4'((i*mul + add) % 16);
            alpha_bank[i*4 +: 4] = bank_arr[i];
        end
    endtask

    function automatic logic [3:0] model_theta(input logic [26:0] op);
        logic [3:0] acc, t;
        for (int k = 0; k < 4; k++) begin
            t = bank_arr[op[k*4 +: 4]];
            if (op[16+k]) t = 4'd15 - t;
            if (k == 0) acc = t;
            else if (op[20+k-1]) acc = (t > acc) ? t : acc;
            else acc = (t < acc) ? t : acc;
        end
        return acc;
    endfunction

    function automatic logic [26:0] make_op(input int s0, input int s1, input int s2,
                                            input int s3, input int neg, input int conn,
                                            input int cons);
        return {4'(cons), 3'(conn), 4'(neg), 4'(s3), 4'(s2), 4'(s1), 4'(s0)};
    endfunction

    task automatic run_rule(input logic [26:0] op, input bit first, input string tag);
        logic [3:0] exp_t, exp_o, c;
        @(negedge clk);
        chk(theta_valid == 1'b0, "R5 pulse width", theta_valid, 0);
        opcode   = op;
        op_valid = 1'b1;
        op_first = first;
        exp_t = model_theta(op);
        c     = op[26:23];
        if (first) for (int i = 0; i < 16; i++) macc[i] = 4'd0;
        exp_o   = (exp_t > macc[c]) ? exp_t : macc[c];
        macc[c] = exp_o;
        sent++;
        @(negedge clk);
        op_valid = 1'b0;
        op_first = 1'b0;
        chk(theta_valid == 1'b1, "R5 valid", theta_valid, 1);
        chk(theta == exp_t, tag, theta, exp_t);
        chk(omega == exp_o, "R7 R8 omega", omega, exp_o);
        chk(cons_idx == c, "R1 cons_idx", cons_idx, c);
    endtask

    initial begin
        #(CLK_PERIOD*60000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] held_t, held_o, held_c;
        rst_n    = 1'b0;
        op_valid = 1'b0;
        op_first = 1'b0;
        opcode   = '0;
        for (int i = 0; i < 16; i++) macc[i] = 4'd0;
        load_bank(1, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(theta_valid == 1'b0, "R9 valid", theta_valid, 0);
        chk(theta == 4'd0, "R9 theta", theta, 0);
        chk(omega == 4'd0, "R9 omega", omega, 0);
        chk(cons_idx == 4'd0, "R9 cons", cons_idx, 0);
        // R9: running maxima start at zero, no pass start needed
        load_bank(3, 5);
        run_rule(make_op(2, 9, 4, 11, 4'b0101, 3'b010, 5), 1'b0, "R9 first rule");

        // R2 R3: sweep of flags and connectives over four banks
        for (int pat = 0; pat < 4; pat++) begin
            load_bank(2*pat + 1, pat*3);
            for (int neg = 0; neg < 16; neg++) begin
                for (int conn = 0; conn < 8; conn++) begin
                    run_rule(make_op((neg + conn*3 + pat) % 16,
                                     (5 + neg + conn*3 + pat) % 16,
                                     (10 + neg + conn*3 + pat) % 16,
                                     (15 + neg + conn*3 + pat) % 16,
                                     neg, conn, (neg + conn) % 16),
                             1'b1, "R2 R3 theta");
                end
            end
        end

        // R4: padded rules by repeated selectors
        load_bank(1, 0);
        run_rule(make_op(9, 9, 9, 9, 4'b0000, 3'b000, 1), 1'b1, "R4 single");
        chk(theta == 4'd9, "R4 single value", theta, 9);
        run_rule(make_op(9, 9, 9, 9, 4'b1111, 3'b101, 2), 1'b1, "R4 single neg");
        chk(theta == 4'd6, "R4 single neg value", theta, 6);
        run_rule(make_op(3, 12, 12, 12, 4'b0000, 3'b000, 3), 1'b1, "R4 pair and");
        chk(theta == 4'd3, "R4 pair and value", theta, 3);
        run_rule(make_op(3, 12, 12, 12, 4'b0000, 3'b111, 3), 1'b1, "R4 pair or");
        chk(theta == 4'd12, "R4 pair or value", theta, 12);

        // R7 R8: merging across a rule stream with two pass starts
        load_bank(7, 2);
        for (int k = 0; k < 60; k++) begin
            run_rule(make_op((k*3) % 16, (k*7 + 1) % 16, (k*11 + 2) % 16, (k*13 + 5) % 16,
                             k % 16, (k*5) % 8, (k*3) % 5),
                     (k == 0) || (k == 30), "R7 R8 theta");
        end

        // R6: opcode churn without valid changes nothing
        held_t = theta;
        held_o = omega;
        held_c = cons_idx;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            opcode   = make_op(k, 15 - k, k*2, 7, k, k, 15 - k);
            op_first = k[0];
            chk(theta_valid == 1'b0, "R6 no pulse", theta_valid, 0);
            chk(theta == held_t, "R6 theta held", theta, held_t);
            chk(omega == held_o, "R6 omega held", omega, held_o);
            chk(cons_idx == held_c, "R6 cons held", cons_idx, held_c);
        end
        op_first = 1'b0;
        // R6: running maxima untouched by the ignored cycles
        run_rule(make_op(0, 0, 0, 0, 4'b0000, 3'b000, 4), 1'b0, "R6 after idle");

        @(negedge clk);
        // R10: one result per accepted rule
        chk(pulses == sent, "R10 result count", pulses, sent);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule